// File: doc/BRIEF.md
# Daisy-Chained Self-Test Sequencer

This block runs the built-in self-test of one node in a chain of battery-cell safety monitors. It watches the test input for a rising edge and passes the request to the node above with one register of delay. As soon as a test starts, it drives every alarm output high. An output is released low only when two things are true: the node's own fault-injection test has reported a pass for that path, and the node above is showing a pass on the same output. A node marked as top or standalone needs only its own pass. In this way the pass indication ripples down the chain, and the bottom node shows a pass only when every node has passed.

The analog fault-injection path is not part of this block. It appears as a done strobe with a per-path fail vector. The block forces a fail in three cases:
- any raw alarm on a path arrives inside a time window on either side of the start edge;
- the local test reports a failure;
- the test pulse falls before the local test has completed.

The window is 20 ms when the deglitch code is zero and 120 ms otherwise. Once set, a fail stays set until the pulse falls.

When the pulse falls, the result is frozen for a hold window. After that, normal alarm reporting resumes: local raw alarms are ORed with the alarms coming from upstream. In shared mode all three outputs carry one combined result. All windows are counted in millisecond ticks, produced by a prescaler whose divide ratio is a parameter.

Top module: `selftest_chain_seq`

## Requirements
- R1: `test_o` equals `test_i` delayed by one clock; it is 0 out of reset.
- R2: In the cycle after a rising edge of `test_i`, all bits of `alarm_o` (bit 0 over-voltage, bit 1 under-voltage, bit 2 over-temperature) are 1.
- R3: While a test runs, `alarm_o[k]` is 0 only after a `local_done_i` strobe. That strobe must have shown no fail on path k, and path k must have no window fail. For a non-top node, `up_alarm_i[k]` must also be 0. Before the strobe, all bits are 1.
- R4: On a node with `is_top_i`=0, an upstream alarm held high during a test keeps the matching output high. On a node with `is_top_i`=1, upstream alarms have no effect.
- R5: A raw alarm on path k less than W ms before the start edge, or less than W ms after it, fails path k. W is 20 when `dgt_code_i`=000 and 120 otherwise. A raw alarm later in the test has no effect.
- R6: With `shared_i`=1, a fail on any path, or an upstream alarm on any bit, drives all three outputs to the same value. With `shared_i`=0, each path is reported on its own.
- R7: If `test_i` falls before a `local_done_i` strobe, the result is fail on all outputs.
- R8: After `test_i` falls, `alarm_o` holds the result present at the fall for HOLD_MS ms. Input changes have no effect during the hold.
- R9: Outside a test, `alarm_o` is the registered value of `alarm_raw_i` ORed with `up_alarm_i`; the upstream term is dropped when `is_top_i`=1. In shared mode it is the OR of all bits, replicated.
- R10: A path that has failed stays high until the pulse falls, even if upstream alarms later clear.
- R11: Out of reset, `alarm_o` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| test_i | input | 1 | Self-test request from the node below (or the host) |
| test_o | output | 1 | Self-test request forwarded to the node above |
| dgt_code_i | input | DGT_W | Deglitch code; zero selects the short window |
| shared_i | input | 1 | 1 = one shared alarm, 0 = separate alarms |
| is_top_i | input | 1 | Node is top of chain or standalone |
| up_alarm_i | input | NPATH | Alarm outputs of the node above |
| alarm_raw_i | input | NPATH | Deglitched local alarms (OV, UV, OT) |
| local_done_i | input | 1 | Strobe: local fault-injection test finished |
| local_fail_i | input | NPATH | Per-path local fail, valid with local_done_i |
| alarm_o | output | NPATH | Alarm outputs to the node below |

## Verification
The hardest case to reach is an alarm that lands just inside or just outside the start window. Its timing depends on the prescaler phase and on which window the deglitch code selects. The stimulus places single-cycle alarm pulses a set number of milliseconds before or after the start edge. The offsets are chosen so that each one falls clearly inside or clearly outside both the 20 ms and the 120 ms windows. The bench then crosses these offsets at random with the deglitch code, shared or separate mode, top or non-top position, upstream alarm patterns and a missing done strobe.

// File: rtl/st_seq_pkg.sv
package st_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } st_state_e;
endpackage

// File: rtl/st_tick.sv
module st_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/st_recent.sv
// Tracks ms since the last raw alarm on one path, saturating.
module st_recent #(
  parameter int SAT_MS = 120,
  localparam int SW = $clog2(SAT_MS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          alarm_i,
  input  logic [SW-1:0] win_ms_i,
  output logic          recent_o
);
  localparam logic [SW-1:0] SAT = SW'(SAT_MS);

  logic [SW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= SAT;
    else if (alarm_i) since_q <= '0;
    else if (tick_i && since_q != SAT) since_q <= since_q + 1'b1;
  end

  assign recent_o = alarm_i || (since_q < win_ms_i);
endmodule

// File: rtl/st_ctrl.sv
module st_ctrl
  import st_seq_pkg::*;
#(
  parameter int NPATH      = 3,
  parameter int WIN_MAX_MS = 120,
  parameter int HOLD_MS    = 50,
  localparam int WW = $clog2(WIN_MAX_MS + 1),
  localparam int HW = $clog2(HOLD_MS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             test_i,
  input  logic [WW-1:0]    win_ms_i,
  input  logic [NPATH-1:0] recent_i,
  input  logic [NPATH-1:0] alarm_raw_i,
  input  logic             local_done_i,
  input  logic [NPATH-1:0] local_fail_i,
  input  logic [NPATH-1:0] pass_now_i,
  output st_state_e        state_o,
  output logic             rise_o,
  output logic             in_win_o,
  output logic             done_o,
  output logic [NPATH-1:0] fail_o,
  output logic [NPATH-1:0] res_o
);
  localparam logic [WW-1:0] WMAX  = WW'(WIN_MAX_MS);
  localparam logic [HW-1:0] HLAST = HW'(HOLD_MS - 1);

  st_state_e        st_q;
  logic             test_q;
  logic [WW-1:0]    run_ms_q;
  logic [HW-1:0]    hold_q;
  logic             done_q;
  logic [NPATH-1:0] fail_q;
  logic [NPATH-1:0] res_q;

  assign rise_o   = test_i && !test_q;
  assign in_win_o = (run_ms_q < win_ms_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      test_q   <= 1'b0;
      run_ms_q <= '0;
      hold_q   <= '0;
      done_q   <= 1'b0;
      fail_q   <= '0;
      res_q    <= '0;
    end else begin
      test_q <= test_i;
      unique case (st_q)
        ST_RUN: begin
          if (!test_i) begin
            st_q   <= ST_HOLD;
            hold_q <= '0;
            res_q  <= ~pass_now_i;
          end else begin
            if (tick_i && run_ms_q != WMAX) run_ms_q <= run_ms_q + 1'b1;
            fail_q <= fail_q
                    | (alarm_raw_i & {NPATH{in_win_o}})
                    | (local_fail_i & {NPATH{local_done_i}});
            if (local_done_i) done_q <= 1'b1;
          end
        end
        default: begin
          if (rise_o) begin
            st_q     <= ST_RUN;
            run_ms_q <= '0;
            done_q   <= 1'b0;
            fail_q   <= recent_i;
          end else if (st_q == ST_HOLD && tick_i) begin
            if (hold_q == HLAST) st_q <= ST_IDLE;
            else hold_q <= hold_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;
  assign fail_o  = fail_q;
  assign res_o   = res_q;

  // R10: failed paths never clear while the pulse stays high
  p_fail_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && test_i) |=> ((fail_q & $past(fail_q)) == $past(fail_q)));
endmodule

// File: rtl/selftest_chain_seq.sv
module selftest_chain_seq
  import st_seq_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int NPATH       = 3,
  parameter int DGT_W       = 3,
  parameter int WIN_ZERO_MS = 20,
  parameter int WIN_NZ_MS   = 120,
  parameter int HOLD_MS     = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             test_i,
  output logic             test_o,
  input  logic [DGT_W-1:0] dgt_code_i,
  input  logic             shared_i,
  input  logic             is_top_i,
  input  logic [NPATH-1:0] up_alarm_i,
  input  logic [NPATH-1:0] alarm_raw_i,
  input  logic             local_done_i,
  input  logic [NPATH-1:0] local_fail_i,
  output logic [NPATH-1:0] alarm_o
);
  localparam int WW = $clog2(WIN_NZ_MS + 1);
  localparam logic [WW-1:0] W_ZERO = WW'(WIN_ZERO_MS);
  localparam logic [WW-1:0] W_NZ   = WW'(WIN_NZ_MS);

  logic             tick;
  logic [WW-1:0]    win_ms;
  logic [NPATH-1:0] recent;
  logic [NPATH-1:0] pass_now;
  logic [NPATH-1:0] fail_q, res_q;
  logic             done_q, rise, in_win;
  st_state_e        st;

  logic [NPATH-1:0] up_eff, up_ok, fail_eff, raw_eff, normal, alarm_d;

  assign win_ms = (dgt_code_i == '0) ? W_ZERO : W_NZ;

  st_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar k = 0; k < NPATH; k++) begin : g_path
    st_recent #(.SAT_MS(WIN_NZ_MS)) u_recent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .alarm_i (alarm_raw_i[k]),
      .win_ms_i(win_ms),
      .recent_o(recent[k])
    );
  end

  st_ctrl #(
    .NPATH     (NPATH),
    .WIN_MAX_MS(WIN_NZ_MS),
    .HOLD_MS   (HOLD_MS)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .test_i      (test_i),
    .win_ms_i    (win_ms),
    .recent_i    (recent),
    .alarm_raw_i (alarm_raw_i),
    .local_done_i(local_done_i),
    .local_fail_i(local_fail_i),
    .pass_now_i  (pass_now),
    .state_o     (st),
    .rise_o      (rise),
    .in_win_o    (in_win),
    .done_o      (done_q),
    .fail_o      (fail_q),
    .res_o       (res_q)
  );

  always_comb begin
    up_eff   = shared_i ? {NPATH{|up_alarm_i}} : up_alarm_i;
    up_ok    = is_top_i ? {NPATH{1'b1}} : ~up_eff;
    fail_eff = shared_i ? {NPATH{|fail_q}} : fail_q;
    pass_now = {NPATH{done_q}} & ~fail_eff & up_ok;
    raw_eff  = alarm_raw_i | (is_top_i ? '0 : up_alarm_i);
    normal   = shared_i ? {NPATH{|raw_eff}} : raw_eff;
    if (rise) alarm_d = {NPATH{1'b1}};
    else begin
      unique case (st)
        ST_RUN:  alarm_d = ~pass_now;
        ST_HOLD: alarm_d = res_q;
        default: alarm_d = normal;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_o <= '0;
      test_o  <= 1'b0;
    end else begin
      alarm_o <= alarm_d;
      test_o  <= test_i;
    end
  end

  p_start_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (alarm_o == {NPATH{1'b1}}));

  // R3 and R7: no release before local completion, including at the fall
  p_no_done_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RUN && !done_q) |=> (alarm_o == {NPATH{1'b1}}));

  p_up_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RUN && !is_top_i) |=> ((alarm_o & $past(up_alarm_i)) == $past(up_alarm_i)));

  p_win_fail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RUN && test_i && in_win && (alarm_raw_i != '0)) |=> (alarm_o != '0));

  p_hold_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_HOLD && $past(st) == ST_HOLD && !rise) |=> $stable(alarm_o));
endmodule

// File: tb/selftest_chain_seq_bench.sv
module selftest_chain_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D      = 4;
  localparam int HOLD   = 50;
  localparam int WZ     = 20;
  localparam int WN     = 120;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic test_i = 1'b0;
  logic [2:0] dgt = 3'd0;
  logic shared = 1'b0, top = 1'b0;
  logic [2:0] up = '0, raw = '0, lfail = '0;
  logic done = 1'b0;
  logic test_o;
  logic [2:0] alarm_o;

  int checks = 0, errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selftest_chain_seq #(.TICK_DIV(D), .HOLD_MS(HOLD), .WIN_ZERO_MS(WZ), .WIN_NZ_MS(WN))
  u_selftest_chain_seq (
    .clk_i(clk), .rst_ni(rst_ni), .test_i(test_i), .test_o(test_o),
    .dgt_code_i(dgt), .shared_i(shared), .is_top_i(top), .up_alarm_i(up),
    .alarm_raw_i(raw), .local_done_i(done), .local_fail_i(lfail), .alarm_o(alarm_o)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [2:0] f_normal(logic [2:0] r, logic [2:0] u, logic t, logic s);
    logic [2:0] e;
    e = r | (t ? 3'b000 : u);
    return s ? {3{|e}} : e;
  endfunction

  function automatic logic [2:0] f_run(logic dn, logic [2:0] fl, logic [2:0] u, logic t, logic s);
    logic [2:0] fe, ue, ok;
    fe = s ? {3{|fl}} : fl;
    ue = s ? {3{|u}} : u;
    ok = t ? 3'b111 : ~ue;
    return ~({3{dn}} & ~fe & ok);
  endfunction

  // pre_ms/post_ms < 0 means no window alarm
  task automatic do_test(input logic [2:0] code, input logic s, input logic t,
                         input logic [2:0] u_run, input logic give_done,
                         input logic [2:0] lf, input int pre_ms, input int pre_p,
                         input int post_ms, input int post_p);
    int w;
    logic [2:0] wf, exp, res, r2, u2;
    w = (code == 3'd0) ? WZ : WN;
    wf = '0;
    @(negedge clk);
    dgt = code; shared = s; top = t; raw = '0; up = '0;
    wn(125 * D);
    if (pre_ms >= 0) begin
      raw[pre_p] = 1'b1; wn(1); raw = '0;
      wn(pre_ms * D);
      if (pre_ms < w) wf[pre_p] = 1'b1;
    end
    test_i = 1'b1;
    wn(1);
    chk("R2 start forces alarms high", alarm_o, 3'b111);
    chk("R1 test forwarded", {2'b00, test_o}, 3'b001);
    up = u_run;
    if (post_ms >= 0) begin
      wn(post_ms * D);
      raw[post_p] = 1'b1; wn(1); raw = '0;
      if (post_ms < w) wf[post_p] = 1'b1;
      wn((130 - post_ms) * D);
    end else wn(130 * D);
    chk("R3 high before done", alarm_o, 3'b111);
    if (give_done) begin
      lfail = lf; done = 1'b1; wn(1); done = 1'b0; lfail = '0;
    end
    wn(3);
    exp = f_run(give_done, (give_done ? lf : 3'b000) | wf, u_run, t, s);
    chk("R3/R4/R5/R6 result with upstream", alarm_o, exp);
    up = '0;
    wn(3);
    exp = f_run(give_done, (give_done ? lf : 3'b000) | wf, 3'b000, t, s);
    chk("R10 result after upstream clears", alarm_o, exp);
    res = exp;
    test_i = 1'b0;
    wn(2);
    if (!give_done) chk("R7 early fall fails all", alarm_o, 3'b111);
    chk("R8 result held after fall", alarm_o, res);
    r2 = 3'($urandom_range(0, 7)); u2 = 3'($urandom_range(0, 7));
    raw = r2; up = u2;
    wn(HOLD * D / 2);
    chk("R8 hold ignores inputs", alarm_o, res);
    wn(HOLD * D / 2 + 6);
    chk("R9 normal reporting resumes", alarm_o, f_normal(r2, u2, t, s));
    chk("R1 forwarded fall", {2'b00, test_o}, 3'b000);
    raw = '0; up = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    int offs[5];
    void'($urandom(32'd4242));
    offs = '{2, 10, 40, 60, 200};
    wn(3);
    chk("R11 reset alarms", alarm_o, 3'b000);
    chk("R11 reset test_o", {2'b00, test_o}, 3'b000);
    rst_ni = 1'b1;
    wn(2);
    // R9 normal, separate and shared, top and non-top
    raw = 3'b010; up = 3'b100; top = 1'b0; shared = 1'b0; wn(2);
    chk("R9 normal separate", alarm_o, 3'b110);
    top = 1'b1; wn(2);
    chk("R9 top ignores upstream", alarm_o, 3'b010);
    shared = 1'b1; wn(2);
    chk("R6 shared normal", alarm_o, 3'b111);
    raw = '0; up = '0;
    // directed corners
    do_test(3'd0, 0, 0, 3'b000, 1, 3'b000, -1, 0, -1, 0);  // clean pass
    do_test(3'd0, 0, 0, 3'b010, 1, 3'b000, -1, 0, -1, 0);  // R4 upstream holds UV
    do_test(3'd0, 0, 1, 3'b111, 1, 3'b000, -1, 0, -1, 0);  // R4 top ignores up
    do_test(3'd0, 0, 0, 3'b000, 0, 3'b000, -1, 0, -1, 0);  // R7 no done
    do_test(3'd0, 0, 0, 3'b000, 1, 3'b100, -1, 0, -1, 0);  // local OT fail
    do_test(3'd0, 1, 0, 3'b000, 1, 3'b001, -1, 0, -1, 0);  // R6 shared fail
    do_test(3'd0, 0, 0, 3'b000, 1, 3'b000, 10, 1, -1, 0);  // R5 pre inside 20
    do_test(3'd0, 0, 0, 3'b000, 1, 3'b000, 40, 1, -1, 0);  // R5 pre outside 20
    do_test(3'd5, 0, 0, 3'b000, 1, 3'b000, 60, 0, -1, 0);  // R5 pre inside 120
    do_test(3'd0, 0, 0, 3'b000, 1, 3'b000, -1, 0, 60, 2);  // R5 post ignored
    do_test(3'd3, 0, 0, 3'b000, 1, 3'b000, -1, 0, 60, 2);  // R5 post inside 120
    for (int i = 0; i < 30; i++) begin
      int pr, po;
      pr = ($urandom_range(0, 2) == 0) ? offs[$urandom_range(0, 4)] : -1;
      po = ($urandom_range(0, 2) == 0) ? offs[$urandom_range(0, 3)] : -1;
      do_test(($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(1, 7)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 1) == 0) ? 3'b000 : 3'($urandom_range(0, 7)),
              ($urandom_range(0, 6) != 0),
              ($urandom_range(0, 1) == 0) ? 3'b000 : 3'($urandom_range(0, 7)),
              pr, $urandom_range(0, 2), po, $urandom_range(0, 2));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule